// File: doc/BRIEF.md
# Edge-Selectable Tach Pulse Divider with Output Blanking

This block sits behind a motor tach sensor whose signal is already a clean rectangular wave synchronised to the system clock. It picks the transitions to count, either rising only or rising and falling, and feeds them to two independent reloadable down-counters. Each counter divides the selected transition stream by its programmed value plus one.

The first counter drives the masked output. After each emitted pulse, a blanking timer suppresses further pulses on that output for a programmable number of ticks. The timer is clocked by one of several prescaler tick inputs. The counter keeps dividing while the output is blanked, so a blanked terminal count is simply lost. The second counter drives the plain output directly, with no blanking.

A host configures the block through a simple write port. Every register write takes effect in the same cycle: a divide value loads its live counter, and a blanking period loads the live blanking timer.

Top module: `pdm_top`

## Requirements
- R1: Control register (address 3) bit 0 selects the counted transitions. A 0 counts rising transitions of `tach_in` only. A 1 counts both rising and falling transitions.
- R2: Each divider counts down on every selected transition. A transition that finds the counter at zero produces a one-cycle output pulse and reloads the counter from its reload value. Pulses therefore arrive once every value+1 transitions. A pulse appears one cycle after the clock edge that first samples the changed input.
- R3: Writing a divide register loads both its reload register and its live counter from `wr_data[6:0]` in that cycle. Address 0 is the masked path and address 1 is the plain path. Such a write takes precedence over a transition arriving in the same cycle.
- R4: `pulse_plain` carries every terminal-count pulse of the address-1 divider and is never blanked.
- R5: After `pulse_masked` fires with blanking register value M, the blanking timer starts. Every further masked-path terminal count is suppressed until M+1 ticks of the selected tick input have occurred. The masked-path divider keeps counting throughout.
- R6: Control register bits [2:1] select which bit of `presc_tick` clocks the blanking timer. While the selected bit stays low, the blanking never ends.
- R7: A write to the blanking register (address 2) also loads the blanking timer in that cycle. A shorter value written during a blanking window therefore shortens that window.
- R8: Reset clears both divide registers and counters, and clears the control register. It sets the blanking register to 8'hFF and holds both outputs low. After reset, every selected transition produces a pulse on both paths, and the first masked pulse opens a 256-tick window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 masked divide, 1 plain divide, 2 blanking period, 3 control |
| wr_data | input | 8 | Write data |
| tach_in | input | 1 | Synchronised tach pulse |
| presc_tick | input | 4 | One-cycle prescaler ticks; one is selected for blanking |
| pulse_masked | output | 1 | Divided pulse after blanking |
| pulse_plain | output | 1 | Divided pulse without blanking |

## Verification
Symmetric square-wave trains are counted under rising-only and both-edge selection. This tells edge doubling apart from a plain divide-ratio error. Divide values of 0 and 3, and a rewrite partway through a count, separate the reload value from the live counter. Pulse trains spaced just inside and just outside the blanking window show the exact window length and show that the plain path is unaffected. A never-ticking tick source, a mid-window period rewrite and the untouched reset period expose the tick selection, the load on write and the reset value of the period register.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    REG_DIV_MASKED = 2'd0,
    REG_DIV_PLAIN  = 2'd1,
    REG_BLANK      = 2'd2,
    REG_CTRL       = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pdm_edge_sel.sv
module pdm_edge_sel (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic both_edges,
  output logic evt
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin;
  end

  assign evt = (pin & ~pin_q) | (both_edges & ~pin & pin_q);
endmodule

// File: rtl/pdm_divider.sv
module pdm_divider #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         evt,
  output logic         pulse
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (ld) begin
        reload_q <= ld_val;
        cnt_q    <= ld_val;
      end else if (evt) begin
        if (cnt_q == '0) begin
          pulse <= 1'b1;
          cnt_q <= reload_q;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(ld_val))); // R3
  AST_TERMINAL_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (evt && !ld && cnt_q == '0) |=> (pulse && cnt_q == $past(reload_q))); // R2
  AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(evt)); // R2
endmodule

// File: rtl/pdm_blanker.sv
module pdm_blanker #(
  parameter int W     = 8,
  parameter int SEL_W = 2,
  localparam int NT   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  input  logic [NT-1:0]    tick_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             pin,
  output logic             pout
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;
  logic         active_q;
  logic         tick;

  assign tick = tick_vec[sel];
  assign pout = pin & ~active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      active_q <= 1'b0;
    end else begin
      if (ld) reload_q <= ld_val;
      if (pin && !active_q) begin
        active_q <= 1'b1;
        cnt_q    <= ld ? ld_val : reload_q;
      end else if (ld) begin
        cnt_q <= ld_val;
      end else if (active_q && tick) begin
        if (cnt_q == '0) active_q <= 1'b0;
        else             cnt_q    <= cnt_q - ONE;
      end
    end
  end

  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (rst)
    (pin && !active_q && !ld) |=> (active_q && cnt_q == $past(reload_q))); // R5
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (active_q && !tick && !ld) |=> (active_q && $stable(cnt_q))); // R6
  AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld && !(pin && !active_q)) |=> (cnt_q == $past(ld_val))); // R7
endmodule

// File: rtl/pdm_top.sv
module pdm_top #(
  parameter int DIV_W  = 7,
  parameter int BLK_W  = 8,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 8,
  localparam int NT    = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tach_in,
  input  logic [NT-1:0]     presc_tick,
  output logic              pulse_masked,
  output logic              pulse_plain
);
  import pdm_pkg::*;

  reg_sel_e         addr;
  logic             both_q;
  logic [SEL_W-1:0] sel_q;
  logic             evt;
  logic             div_m_pulse;
  logic             wr_div_m;
  logic             wr_div_p;
  logic             wr_blank;
  logic             wr_ctrl;

  assign addr     = reg_sel_e'(wr_addr);
  assign wr_div_m = wr_en && addr == REG_DIV_MASKED;
  assign wr_div_p = wr_en && addr == REG_DIV_PLAIN;
  assign wr_blank = wr_en && addr == REG_BLANK;
  assign wr_ctrl  = wr_en && addr == REG_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      both_q <= 1'b0;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      both_q <= wr_data[0];
      sel_q  <= wr_data[SEL_W:1];
    end
  end

  pdm_edge_sel u_edge (
    .clk(clk), .rst(rst), .pin(tach_in), .both_edges(both_q), .evt(evt)
  );

  pdm_divider #(.W(DIV_W)) u_div_m (
    .clk(clk), .rst(rst), .ld(wr_div_m), .ld_val(wr_data[DIV_W-1:0]),
    .evt(evt), .pulse(div_m_pulse)
  );

  pdm_divider #(.W(DIV_W)) u_div_p (
    .clk(clk), .rst(rst), .ld(wr_div_p), .ld_val(wr_data[DIV_W-1:0]),
    .evt(evt), .pulse(pulse_plain)
  );

  pdm_blanker #(.W(BLK_W), .SEL_W(SEL_W)) u_blank (
    .clk(clk), .rst(rst), .ld(wr_blank), .ld_val(wr_data[BLK_W-1:0]),
    .tick_vec(presc_tick), .sel(sel_q), .pin(div_m_pulse), .pout(pulse_masked)
  );

  AST_MASKED_FROM_DIVIDER: assert property (@(posedge clk) disable iff (rst)
    pulse_masked |-> $past(evt)); // R5
endmodule

// File: tb/pdm_top_tb_top.sv
`timescale 1ns/1ps
module pdm_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tach_in = 1'b0;
  logic [3:0] presc_tick = '0;
  logic       pulse_masked;
  logic       pulse_plain;

  int checks = 0;
  int errors = 0;
  int cnt_m = 0;
  int cnt_p = 0;
  int cyc = 0;
  int base_m;
  int base_p;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdm_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tach_in(tach_in), .presc_tick(presc_tick),
    .pulse_masked(pulse_masked), .pulse_plain(pulse_plain)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    presc_tick[0] <= 1'b1;
    presc_tick[1] <= (cyc % 4) == 0;
    presc_tick[2] <= (cyc % 16) == 0;
    presc_tick[3] <= 1'b0;
    if (!rst && pulse_masked) cnt_m <= cnt_m + 1;
    if (!rst && pulse_plain)  cnt_p <= cnt_p + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1;
      repeat (hi) @(negedge clk);
      tach_in = 1'b0;
      repeat (lo) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic mark();
    @(negedge clk);
    base_m = cnt_m; base_p = cnt_p;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R8 masked low in reset", int'(pulse_masked), 0);
    check("R8 plain low in reset", int'(pulse_plain), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 masked low after reset", int'(pulse_masked), 0);
    check("R8 plain low after reset", int'(pulse_plain), 0);
  endtask

  task automatic t_reset_values();
    mark();
    edges(40, 4, 4);
    check("R8 plain divide-by-one after reset", cnt_p - base_p, 40);
    check("R8 reset blanking 256 ticks", cnt_m - base_m, 2);
    repeat (260) @(negedge clk);
  endtask

  task automatic t_rising();
    wr(2'd3, 8'h00); wr(2'd2, 8'd0); wr(2'd0, 8'd3); wr(2'd1, 8'd3);
    mark();
    edges(8, 3, 3);
    check("R1 R2 rising only plain", cnt_p - base_p, 2);
    check("R1 R2 rising only masked", cnt_m - base_m, 2);
  endtask

  task automatic t_both();
    wr(2'd3, 8'h01); wr(2'd0, 8'd3); wr(2'd1, 8'd3);
    mark();
    edges(8, 3, 3);
    check("R1 both edges plain", cnt_p - base_p, 4);
    check("R1 both edges masked", cnt_m - base_m, 4);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_div_one();
    wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    mark();
    edges(5, 3, 3);
    check("R2 divide by one plain", cnt_p - base_p, 5);
    check("R2 divide by one masked", cnt_m - base_m, 5);
  endtask

  task automatic t_live_reload();
    wr(2'd0, 8'd5); wr(2'd1, 8'd5);
    mark();
    edges(3, 3, 3);
    check("R3 no pulse mid count", cnt_p - base_p, 0);
    wr(2'd0, 8'd1); wr(2'd1, 8'd1);
    edges(1, 3, 3);
    check("R3 reloaded counter first edge", cnt_p - base_p, 0);
    edges(1, 3, 3);
    check("R3 reloaded counter plain", cnt_p - base_p, 1);
    check("R3 reloaded counter masked", cnt_m - base_m, 1);
  endtask

  task automatic t_blanking();
    wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    wr(2'd3, 8'h02); wr(2'd2, 8'd10);
    mark();
    edges(10, 4, 4);
    check("R5 blanked masked count", cnt_m - base_m, 2);
    check("R4 plain path unblanked", cnt_p - base_p, 10);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_blank_write();
    wr(2'd2, 8'd200);
    mark();
    edges(1, 4, 4);
    check("R7 first pulse passes", cnt_m - base_m, 1);
    edges(2, 4, 4);
    check("R7 long window blanks", cnt_m - base_m, 1);
    wr(2'd2, 8'd0);
    repeat (8) @(negedge clk);
    edges(1, 4, 4);
    check("R7 rewrite shortens window", cnt_m - base_m, 2);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_tick_sel();
    wr(2'd2, 8'd0); wr(2'd3, 8'h06);
    mark();
    edges(1, 4, 4);
    check("R6 first pulse with idle tick", cnt_m - base_m, 1);
    edges(3, 4, 4);
    check("R6 idle tick keeps window", cnt_m - base_m, 1);
    wr(2'd3, 8'h00);
    repeat (4) @(negedge clk);
    edges(1, 4, 4);
    check("R6 reselected tick releases", cnt_m - base_m, 2);
    check("R6 plain path unaffected", cnt_p - base_p, 5);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reset_values();
    t_rising();
    t_both();
    t_div_one();
    t_live_reload();
    t_blanking();
    t_blank_write();
    t_tick_sel();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule